// File: doc/BRIEF.md
# Sixteen-Lane 3x-Oversampled Serial Receive Bank

This block receives asynchronous serial characters on many lines at once. A single internal divider produces a sampling strobe every `TICK_DIV` clocks. The bit rate is `OVERSAMPLE` strobes per bit, which is three by default and four as an option. On each strobe every receive line is registered in the same clock edge. The lines are held in registers 8 lanes wide. Per-lane decoding then works only on that frozen copy, so no lane's timing depends on where it sits in the bank.

Each lane runs a small state machine:

- A low sample seen while the lane is idle arms a start check.
- The following sample must also be low for the start bit to be accepted.
- After that, one sample every `OVERSAMPLE` strobes is taken as the next data bit. The bits arrive least significant first, eight of them, followed by one stop bit.
- When the stop sample is taken, the lane presents its byte with a one-clock valid pulse and reports whether the stop bit was low.

The default divider gives 9600 bit/s at a 125 MHz clock with 3x sampling. Each lane feeds its own byte consumer, for example a packet deframer.

Top module: `serial_rx_bank`

## Requirements
- R1: The sampling strobe repeats every `TICK_DIV` clocks, so one bit lasts `OVERSAMPLE*TICK_DIV` clocks; the default `TICK_DIV` of 4340 gives 9600 bit/s at 125 MHz with 3x sampling.
- R2: On a strobe all `NUM_CH` inputs are registered together in 8-lane groups, and a lane decodes only that registered copy, so characters that start at the same instant on different lanes decode identically.
- R3: An idle lane that samples a low level moves to a start check, and the start is accepted only when the next sample is also low.
- R4: If the start-check sample is high, the lane returns to idle and produces no valid pulse; a low pulse caught by only one sample therefore yields no output, and the next full character still decodes.
- R5: After an accepted start, every `OVERSAMPLE`-th sample is taken as the next data bit; the first data bit on the line lands in bit 0 of the lane's byte.
- R6: At the stop sample the lane drives its byte on `rx_data[8*c +: 8]` and pulses `rx_valid[c]` high for exactly one clock, two clocks after the strobe that captured the stop sample.
- R7: `frame_err[c]` is 1 when the stop sample was low and 0 when it was high; it changes only together with `rx_valid[c]` and holds until that lane's next valid pulse, and the byte is still delivered.
- R8: A character sent at a bit period up to 2% longer or shorter than nominal decodes correctly for any start alignment with the strobe.
- R9: Lanes are independent: activity on some lanes produces no valid pulse on idle lanes.
- R10: During reset `rx_valid`, `frame_err` and `rx_data` are all zero, and the captured line copy is held at the idle (high) level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_in | input | NUM_CH | Serial receive lines, idle high, lane c on bit c |
| rx_data | output | 8*NUM_CH | Last received byte of each lane, lane c on bits 8c+7..8c |
| rx_valid | output | NUM_CH | One-clock pulse per lane when its byte is presented |
| frame_err | output | NUM_CH | Per lane: stop sample of the last character was low |

## Verification
A lane's valid pulse is due two clocks after the strobe that captures its stop sample. That strobe falls between 9.33 and 9.67 nominal bit periods after the falling start edge, depending on where the edge lands relative to the strobe. The bench therefore drives a whole character, keeps the lines idle for two more bit periods and only then compares. A monitor sampling on the falling clock edge records every pulse, which exposes both a missing pulse and one held for more than one clock.

Rejected starts are checked after four idle bit periods, by which time any pulse would already be due. The 2% tolerance runs use whole-clock bit periods one clock off the nominal 48.

// File: rtl/srx_pkg.sv
// Shared definitions for the serial receive bank.
// Assumes 8-bit characters with one start and one stop bit.
package srx_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        LANE_IDLE  = 2'd0,
        LANE_CHECK = 2'd1,
        LANE_DATA  = 2'd2,
        LANE_STOP  = 2'd3
    } lane_state_t;
endpackage

// File: rtl/srx_strobe_gen.sv
// Divides the clock down to the sampling strobe: one clock-wide pulse every
// DIV clocks. Assumes DIV >= 1; the first strobe follows DIV clocks after reset.
module srx_strobe_gen #(
    parameter int DIV = 4340
) (
    input  logic clk,
    input  logic rst_n,
    output logic strobe
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] div_cnt;

    // Free-running divide counter, wrapping at DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n)                      div_cnt <= '0;
        else if (div_cnt == CW'(DIV - 1)) div_cnt <= '0;
        else                             div_cnt <= div_cnt + 1'b1;
    end

    assign strobe = (div_cnt == CW'(DIV - 1));

    generate
        if (DIV > 1) begin : g_gap_chk
            p_strobe_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
                strobe |=> !strobe)
                else $error("strobe held high for two clocks");
        end
    endgenerate
endmodule

// File: rtl/srx_line_capture.sv
// Registers every receive line on the same strobe edge, in groups of GRP lanes,
// and delays the strobe by one clock so that decoders see the frozen copy.
// Assumes NUM_CH is a multiple of GRP. Lines reset to the idle (high) level.
module srx_line_capture #(
    parameter int NUM_CH = 16,
    parameter int GRP    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [NUM_CH-1:0] lines,
    output logic [NUM_CH-1:0] snap,
    output logic              snap_stb
);
    localparam int N_GRP = NUM_CH / GRP;

    generate
        for (genvar g = 0; g < N_GRP; g++) begin : g_grp
            logic [GRP-1:0] grp_q;
            // Latch one group of lanes on the shared strobe.
            always_ff @(posedge clk) begin
                if (!rst_n)      grp_q <= '1;
                else if (strobe) grp_q <= lines[g*GRP +: GRP];
            end
            assign snap[g*GRP +: GRP] = grp_q;
        end
    endgenerate

    // Tell the decoders that a fresh snapshot is present.
    always_ff @(posedge clk) begin
        if (!rst_n) snap_stb <= 1'b0;
        else        snap_stb <= strobe;
    end

    p_snap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(snap))
        else $error("snapshot changed without a strobe");
    p_snap_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> snap_stb)
        else $error("snapshot strobe missing");
endmodule

// File: rtl/srx_lane.sv
// One receive lane: start check, centred data sampling every OS samples, stop
// check. Acts only when smp_stb is high, on the captured sample smp.
// Assumes OS >= 2.
module srx_lane
    import srx_pkg::*;
#(
    parameter int OS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_stb,
    input  logic              smp,
    output logic [BYTE_W-1:0] byte_o,
    output logic              valid_o,
    output logic              err_o
);
    localparam int PW = (OS > 1) ? $clog2(OS) : 1;
    localparam int BW = $clog2(BYTE_W);

    lane_state_t       st;
    logic [PW-1:0]     phase;
    logic [BW-1:0]     bit_n;
    logic [BYTE_W-1:0] shreg;
    logic              phase_end;

    assign phase_end = (phase == PW'(OS - 1));

    // Lane state machine with shift register and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= LANE_IDLE;
            phase   <= '0;
            bit_n   <= '0;
            shreg   <= '0;
            byte_o  <= '0;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (smp_stb) begin
                unique case (st)
                    LANE_IDLE: begin
                        if (!smp) st <= LANE_CHECK;
                    end
                    LANE_CHECK: begin
                        phase <= '0;
                        bit_n <= '0;
                        st    <= smp ? LANE_IDLE : LANE_DATA;
                    end
                    LANE_DATA: begin
                        if (phase_end) begin
                            phase <= '0;
                            shreg <= {smp, shreg[BYTE_W-1:1]};
                            if (bit_n == BW'(BYTE_W - 1)) st <= LANE_STOP;
                            else                        bit_n <= bit_n + 1'b1;
                        end else begin
                            phase <= phase + 1'b1;
                        end
                    end
                    LANE_STOP: begin
                        if (phase_end) begin
                            phase   <= '0;
                            byte_o  <= shreg;
                            err_o   <= !smp;
                            valid_o <= 1'b1;
                            st      <= LANE_IDLE;
                        end else begin
                            phase <= phase + 1'b1;
                        end
                    end
                    default: st <= LANE_IDLE;
                endcase
            end
        end
    end

    p_start_detect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LANE_IDLE && smp_stb && !smp) |=> st == LANE_CHECK)
        else $error("low idle sample did not arm start check");
    p_check_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LANE_CHECK && smp_stb && smp) |=> (st == LANE_IDLE && !valid_o))
        else $error("high check sample did not return to idle");
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o)
        else $error("valid longer than one clock");
    p_valid_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(st) == LANE_STOP)
        else $error("valid outside stop state");
    p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(err_o))
        else $error("error flag moved without valid");
endmodule

// File: rtl/serial_rx_bank.sv
// Bank of NUM_CH asynchronous serial receivers sharing one sampling strobe at
// OVERSAMPLE times the bit rate. Assumes NUM_CH is a multiple of GRP and
// OVERSAMPLE is 3 or 4. Lines idle high.
module serial_rx_bank
    import srx_pkg::*;
#(
    parameter int NUM_CH     = 16,
    parameter int GRP        = 8,
    parameter int OVERSAMPLE = 3,
    parameter int TICK_DIV   = 4340
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        rx_in,
    output logic [NUM_CH*BYTE_W-1:0] rx_data,
    output logic [NUM_CH-1:0]        rx_valid,
    output logic [NUM_CH-1:0]        frame_err
);
    logic              strobe;
    logic [NUM_CH-1:0] snap;
    logic              snap_stb;

    srx_strobe_gen #(.DIV(TICK_DIV)) u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe)
    );

    srx_line_capture #(.NUM_CH(NUM_CH), .GRP(GRP)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (strobe),
        .lines    (rx_in),
        .snap     (snap),
        .snap_stb (snap_stb)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
            srx_lane #(.OS(OVERSAMPLE)) u_lane (
                .clk     (clk),
                .rst_n   (rst_n),
                .smp_stb (snap_stb),
                .smp     (snap[c]),
                .byte_o  (rx_data[c*BYTE_W +: BYTE_W]),
                .valid_o (rx_valid[c]),
                .err_o   (frame_err[c])
            );
        end
    endgenerate
endmodule

// File: tb/tb_serial_rx_bank.sv
`timescale 1ns/1ps
module tb_serial_rx_bank;
    localparam int NCH = 16;
    localparam int OS  = 3;
    localparam int DIV = 16;
    localparam int P   = OS * DIV;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    rx_in = '1;
    logic [NCH*8-1:0]  rx_data;
    logic [NCH-1:0]    rx_valid;
    logic [NCH-1:0]    frame_err;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int       tot_cnt [NCH];
    int       base_cnt[NCH];
    logic [7:0] got_byte[NCH];
    logic       got_err [NCH];
    logic [7:0] exp_byte[NCH];
    logic       exp_stop[NCH];
    logic       active  [NCH];

    always #4 clk = ~clk;

    serial_rx_bank #(.NUM_CH(NCH), .GRP(8), .OVERSAMPLE(OS), .TICK_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in),
        .rx_data(rx_data), .rx_valid(rx_valid), .frame_err(frame_err)
    );

    initial for (int c = 0; c < NCH; c++) tot_cnt[c] = 0;

    // Monitor: record every valid pulse, one count per clock it is high.
    always @(negedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (rx_valid[c]) begin
                tot_cnt[c]  = tot_cnt[c] + 1;
                got_byte[c] = rx_data[c*8 +: 8];
                got_err[c]  = frame_err[c];
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic snap_base();
        for (int c = 0; c < NCH; c++) base_cnt[c] = tot_cnt[c];
    endtask

    // Drive one character on active lanes with the given bit period.
    task automatic drive_frame(input int per);
        snap_base();
        for (int b = 0; b < 10; b++) begin
            for (int c = 0; c < NCH; c++) begin
                if (!active[c])  rx_in[c] = 1'b1;
                else if (b == 0) rx_in[c] = 1'b0;
                else if (b == 9) rx_in[c] = exp_stop[c];
                else             rx_in[c] = exp_byte[c][b-1];
            end
            repeat (per) @(negedge clk);
        end
        rx_in = '1;
        repeat (2 * P) @(negedge clk);
    endtask

    task automatic verify_round(input string req);
        for (int c = 0; c < NCH; c++) begin
            int n = tot_cnt[c] - base_cnt[c];
            if (active[c]) begin
                check(n == 1, {req, " R6 pulse count"}, n, 1);
                if (n == 1) begin
                    check(got_byte[c] == exp_byte[c], {req, " R5 byte"}, got_byte[c], exp_byte[c]);
                    check(got_err[c] == !exp_stop[c], {req, " R7 frame_err"}, got_err[c], !exp_stop[c]);
                end
            end else begin
                check(n == 0, {req, " R9 idle lane"}, n, 0);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset values
        check(rx_valid == '0, "R10 valid", rx_valid, 0);
        check(frame_err == '0, "R10 frame_err", frame_err, 0);
        check(rx_data == '0, "R10 data", 0, 0);
        rst_n = 1'b1;
        repeat (2 * P) @(negedge clk);

        // R1 R2 R5 R6: all 256 byte values, every lane active at once
        for (int k = 0; k < 16; k++) begin
            for (int c = 0; c < NCH; c++) begin
                active[c]   = 1'b1;
                exp_stop[c] = 1'b1;
                exp_byte[c] = 8'(((k * 16 + c) * 77 + 3) % 256);
            end
            drive_frame(P);
            verify_round("R2 sweep");
        end

        // R7: low stop on odd lanes
        for (int c = 0; c < NCH; c++) begin
            active[c] = 1'b1; exp_stop[c] = c[0] ? 1'b0 : 1'b1; exp_byte[c] = 8'(c * 19);
        end
        drive_frame(P);
        verify_round("R7 low stop");
        // R7: flag clears on next good frame
        for (int c = 0; c < NCH; c++) begin exp_stop[c] = 1'b1; exp_byte[c] = 8'(255 - c); end
        drive_frame(P);
        verify_round("R7 clear");

        // R9: only even lanes active
        for (int c = 0; c < NCH; c++) begin
            active[c] = !c[0]; exp_stop[c] = 1'b1; exp_byte[c] = 8'(8'hA5 ^ c);
        end
        drive_frame(P);
        verify_round("R9 sparse");

        // R3 R4: single-sample glitch yields nothing
        for (int g = 0; g < 3; g++) begin
            snap_base();
            repeat (g * 5) @(negedge clk);
            rx_in = '0;
            repeat (DIV) @(negedge clk);
            rx_in = '1;
            repeat (4 * P) @(negedge clk);
            for (int c = 0; c < NCH; c++)
                check(tot_cnt[c] == base_cnt[c], "R4 glitch", tot_cnt[c] - base_cnt[c], 0);
        end
        for (int c = 0; c < NCH; c++) begin
            active[c] = 1'b1; exp_stop[c] = 1'b1; exp_byte[c] = 8'(c * 13 + 1);
        end
        drive_frame(P);
        verify_round("R4 after glitch");

        // R3: two-sample start accepted at various alignments; R8 rate mismatch
        for (int r = 0; r < 8; r++) begin
            repeat (r * 3) @(negedge clk);
            for (int c = 0; c < NCH; c++) begin
                active[c] = 1'b1; exp_stop[c] = 1'b1; exp_byte[c] = 8'(r * 31 + c * 7);
            end
            drive_frame(r[0] ? P + 1 : P - 1);
            verify_round("R8 R3 rate");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule